// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a larger chip. A 32-bit down-counter runs on the block clock and is reloaded from a programmable load value. When the counter first reaches zero it raises an interrupt and starts a new period. Software must clear that interrupt before the counter reaches zero a second time. If the interrupt is still pending at the second expiry and reset is enabled, the block emits a one-cycle system reset pulse.

Every register except the lock register is write-protected. Software writes a 32-bit key to the lock register to open the block. It then reprograms the block and writes any other value to close it again. The register port is a plain single-cycle interface. A write is taken on the clock edge when select and write are both high. Read data is combinational from the address.

Register map (byte offsets): 0x000 load value (read/write), 0x004 live count (read-only), 0x008 control (read/write), 0x00C interrupt clear (write-only, reads 0), 0x010 raw status, 0x014 masked status, 0xC00 lock. Unmapped offsets read 0.

Top module: `wdog_guard`

## Requirements
- R1: After reset the block is locked (lock register bit 0 reads 1), control reads 0, the load value reads 0xFFFFFFFF, both status registers read 0, and `irq_o` and `sys_rst_o` are low.
- R2: While locked, writes to the load, control and interrupt-clear registers are ignored, and the state they would change is unchanged.
- R3: Writing 0x1ACCE551 to offset 0xC00 unlocks the block, so bit 0 reads 0. Writing any other value there locks it. Lock writes are accepted in either state.
- R4: Control bit 0 is reset enable and bit 1 is count enable. Bits 31:2 read as zero, whatever value was written.
- R5: A control write that takes count enable from 0 to 1 loads the counter from the load value. After that the counter decrements by one each clock while enabled.
- R6: In a clock where the counter is enabled and at zero, raw status (bit 0 of 0x010) is set and the counter reloads from the load value. A period therefore lasts load+1 clocks.
- R7: Any unlocked write to offset 0x00C clears raw status and reloads the counter. A clear issued between the first and second expiry prevents the reset pulse.
- R8: Masked status (bit 0 of 0x014) and `irq_o` equal raw status AND count enable.
- R9: An expiry that finds raw status already set, with reset enable 1, makes `sys_rst_o` high for exactly one cycle. With reset enable 0 the pulse never occurs.
- R10: While count enable is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; counter and registers |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, taken at the clock edge when selected |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Masked watchdog interrupt |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions watch properties that hold on every clock: the reset request never lasts more than one cycle, and it appears only with reset enable set and the interrupt pending. The interrupt output never rises while counting is disabled. A disabled counter never moves. While locked, the load value never changes, and a zero count always sets raw status. The bench scenarios show the exact expiry timing, which needs the full period arithmetic from the load value. They also show the key and lock sequencing through the register port, and that a timely interrupt clear or a cleared reset-enable bit suppresses the reset pulse.

// File: rtl/wdog_pkg.sv
// Package: shared offsets, key and control bit positions for the watchdog.
// Assumes a 12-bit byte address and 32-bit registers.
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

    localparam logic [DATA_W-1:0] OPEN_KEY  = 32'h1ACC_E551;

    localparam int BIT_RSTEN = 0;
    localparam int BIT_RUN   = 1;
endpackage

// File: rtl/wdog_regfile.sv
// Register file: lock state, load value and control bits, write decode and read mux.
// Assumes single-cycle writes (sel & wr) and combinational reads.
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] cnt_i,
    input  logic          raw_i,
    input  logic          irq_i,
    output logic [DW-1:0] load_o,
    output logic          run_o,
    output logic          rsten_o,
    output logic          locked_o,
    output logic          clr_ev_o,
    output logic          reload_ev_o
);
    logic any_wr, open_wr;
    logic hit_load, hit_ctrl, hit_clr, hit_lock;

    // Decode the access and the address hits.
    always_comb begin
        any_wr   = bus_sel && bus_wr;
        open_wr  = any_wr && !locked_o;
        hit_load = bus_addr == OFF_LOAD;
        hit_ctrl = bus_addr == OFF_CTRL;
        hit_clr  = bus_addr == OFF_CLR;
        hit_lock = bus_addr == OFF_LOCK;
    end

    // Events the counter and status logic act on this cycle.
    always_comb begin
        clr_ev_o    = open_wr && hit_clr;
        reload_ev_o = clr_ev_o || (open_wr && hit_ctrl && bus_wdata[BIT_RUN] && !run_o);
    end

    // Lock register: only the exact key opens; any other value closes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 locked_o <= 1'b1;
        else if (any_wr && hit_lock) locked_o <= (bus_wdata != OPEN_KEY);
    end

    // Load value and control bits, written only while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o  <= '1;
            run_o   <= 1'b0;
            rsten_o <= 1'b0;
        end else begin
            if (open_wr && hit_load) load_o <= bus_wdata;
            if (open_wr && hit_ctrl) begin
                run_o   <= bus_wdata[BIT_RUN];
                rsten_o <= bus_wdata[BIT_RSTEN];
            end
        end
    end

    // Read mux; reserved bits and unmapped offsets give zero.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_LOAD:  bus_rdata = load_o;
            OFF_COUNT: bus_rdata = cnt_i;
            OFF_CTRL: begin
                bus_rdata[BIT_RUN]   = run_o;
                bus_rdata[BIT_RSTEN] = rsten_o;
            end
            OFF_RAW:   bus_rdata[0] = raw_i;
            OFF_MASK:  bus_rdata[0] = irq_i;
            OFF_LOCK:  bus_rdata[0] = locked_o;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_downcnt.sv
// Down-counter: reloads on request, decrements while running, reloads after zero.
// Assumes reload requests take priority over counting in the same cycle.
module wdog_downcnt #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          reload_i,
    input  logic [DW-1:0] load_i,
    output logic [DW-1:0] cnt_o,
    output logic          expire_o
);
    // Expiry: enabled, at zero, and not overridden by a reload.
    always_comb expire_o = run_i && (cnt_o == '0) && !reload_i;

    // Counter state update.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_o <= '1;
        else if (reload_i)      cnt_o <= load_i;
        else if (run_i) begin
            if (cnt_o == '0)    cnt_o <= load_i;
            else                cnt_o <= cnt_o - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_alarm.sv
// Alarm stage: raw interrupt status, masked interrupt and the reset pulse.
// Assumes expire_i and clr_i never both high (clear suppresses expiry upstream).
module wdog_alarm (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clr_i,
    input  logic run_i,
    input  logic rsten_i,
    output logic raw_o,
    output logic irq_o,
    output logic rst_o
);
    // Raw status: set on expiry, cleared by the clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw_o <= 1'b0;
        else if (clr_i)    raw_o <= 1'b0;
        else if (expire_i) raw_o <= 1'b1;
    end

    // Second-stage reset: expiry with status pending, never two cycles running.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_o <= 1'b0;
        else        rst_o <= expire_i && raw_o && rsten_i && !rst_o;
    end

    // Interrupt output follows the masked status.
    always_comb irq_o = raw_o && run_i;
endmodule

// File: rtl/wdog_guard.sv
// Top: lockable two-stage watchdog with a single-cycle register port.
// Assumes one clock domain and a synchronous active-low reset.
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          sys_rst_o
);
    logic [DW-1:0] load_q, cnt_q;
    logic run_q, rsten_q, locked_q, clr_ev, reload_ev, expire, raw_q;

    wdog_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt_q), .raw_i(raw_q), .irq_i(irq_o),
        .load_o(load_q), .run_o(run_q), .rsten_o(rsten_q), .locked_o(locked_q),
        .clr_ev_o(clr_ev), .reload_ev_o(reload_ev)
    );

    wdog_downcnt #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run_q), .reload_i(reload_ev),
        .load_i(load_q), .cnt_o(cnt_q), .expire_o(expire)
    );

    wdog_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .clr_i(clr_ev),
        .run_i(run_q), .rsten_i(rsten_q),
        .raw_o(raw_q), .irq_o(irq_o), .rst_o(sys_rst_o)
    );
endmodule

// File: rtl/wdog_guard_chk.sv
// Checker: cycle-level properties of the watchdog, bound into wdog_guard.
module wdog_guard_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sys_rst_o,
    input logic          irq_o,
    input logic          run_q,
    input logic          rsten_q,
    input logic          raw_q,
    input logic          locked_q,
    input logic          reload_ev,
    input logic [DW-1:0] load_q,
    input logic [DW-1:0] cnt_q
);
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);
    a_r9_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> $past(rsten_q));
    a_r9_pulse_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> raw_q);
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> run_q);
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !reload_ev) |=> $stable(cnt_q));
    a_r2_locked_load: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable(load_q));
    a_r6_zero_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q == '0 && !reload_ev) |=> raw_q);
endmodule

bind wdog_guard wdog_guard_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
    .run_q(run_q), .rsten_q(rsten_q), .raw_q(raw_q), .locked_q(locked_q),
    .reload_ev(reload_ev), .load_q(load_q), .cnt_q(cnt_q)
);

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    wdog_guard dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o));

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_IDLE = 2'd2;
    localparam logic [31:0] KEY = 32'h1ACCE551;
    localparam int NV = 39;
    // {op, addr, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {OP_RD, 12'hC00, 32'h0, 32'h1},          // R1 locked
        {OP_RD, 12'h000, 32'h0, 32'hFFFFFFFF},   // R1 load
        {OP_RD, 12'h008, 32'h0, 32'h0},          // R1 ctrl
        {OP_RD, 12'h010, 32'h0, 32'h0},          // R1 raw
        {OP_WR, 12'h000, 32'd10, 32'h0},
        {OP_RD, 12'h000, 32'h0, 32'hFFFFFFFF},   // R2 load write ignored
        {OP_WR, 12'hC00, KEY, 32'h0},
        {OP_RD, 12'hC00, 32'h0, 32'h0},          // R3 open
        {OP_WR, 12'h008, 32'h1, 32'h0},
        {OP_RD, 12'h008, 32'h0, 32'h1},          // R4 reset enable
        {OP_WR, 12'h008, 32'hFFFFFFFE, 32'h0},
        {OP_RD, 12'h008, 32'h0, 32'h2},          // R4 reserved zero
        {OP_WR, 12'h008, 32'h0, 32'h0},
        {OP_RD, 12'h004, 32'h0, 32'hFFFFFFFE},   // R5 one decrement
        {OP_IDLE, 12'h0, 32'd3, 32'h0},
        {OP_RD, 12'h004, 32'h0, 32'hFFFFFFFE},   // R10 hold
        {OP_WR, 12'h000, 32'd4, 32'h0},
        {OP_WR, 12'h008, 32'h2, 32'h0},
        {OP_RD, 12'h004, 32'h0, 32'd4},          // R5 reload on rise
        {OP_IDLE, 12'h0, 32'd2, 32'h0},
        {OP_RD, 12'h004, 32'h0, 32'd2},          // R5 counting
        {OP_IDLE, 12'h0, 32'd2, 32'h0},
        {OP_RD, 12'h004, 32'h0, 32'd0},          // R5 at zero
        {OP_RD, 12'h010, 32'h0, 32'h0},          // R6 not yet
        {OP_IDLE, 12'h0, 32'd1, 32'h0},
        {OP_RD, 12'h010, 32'h0, 32'h1},          // R6 raw set
        {OP_RD, 12'h004, 32'h0, 32'd4},          // R6 reloaded
        {OP_RD, 12'h014, 32'h0, 32'h1},          // R8 masked on
        {OP_WR, 12'h008, 32'h0, 32'h0},
        {OP_RD, 12'h014, 32'h0, 32'h0},          // R8 masked off
        {OP_RD, 12'h010, 32'h0, 32'h1},          // R8 raw kept
        {OP_RD, 12'h004, 32'h0, 32'd3},          // R10 stopped
        {OP_WR, 12'h00C, 32'h0, 32'h0},
        {OP_RD, 12'h010, 32'h0, 32'h0},          // R7 cleared
        {OP_RD, 12'h004, 32'h0, 32'd4},          // R7 reloaded
        {OP_WR, 12'hC00, 32'h0, 32'h0},
        {OP_RD, 12'hC00, 32'h0, 32'h1},          // R3 relocked
        {OP_WR, 12'h008, 32'h2, 32'h0},
        {OP_RD, 12'h008, 32'h0, 32'h0}           // R2 ctrl write ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 rst", {31'b0, sys_rst_o}, 32'h0);
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            if (op == OP_WR) wr(a, d);
            else if (op == OP_IDLE) repeat (d) @(negedge clk);
            else begin
                rd(a, v);
                check($sformatf("vector %0d", i), v, e);
            end
        end

        // R9 / R8: two expiries with reset enabled give one pulse each time.
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd5); wr(12'h008, 32'h3);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            check($sformatf("R9 pulse k=%0d", k), {31'b0, sys_rst_o}, {31'b0, (k == 12 || k == 18)});
            check($sformatf("R8 irq k=%0d", k), {31'b0, irq_o}, {31'b0, (k >= 6)});
        end

        // R9: reset enable 0 means no pulse.
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd3); wr(12'h008, 32'h2);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            check("R9 no pulse when disabled", {31'b0, sys_rst_o}, 32'h0);
        end

        // R7: clearing between expiries prevents the pulse.
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd5); wr(12'h008, 32'h3);
        repeat (8) @(negedge clk);
        rd(12'h010, v); check("R7 raw before clear", v, 32'h1);
        wr(12'h00C, 32'h0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R7 no pulse after clear", {31'b0, sys_rst_o}, 32'h0);
        end

        // R2: clear write while locked leaves raw status set.
        do_reset();
        wr(12'hC00, KEY); wr(12'h000, 32'd2); wr(12'h008, 32'h2);
        repeat (4) @(negedge clk);
        wr(12'hC00, 32'h0);
        wr(12'h00C, 32'h0);
        rd(12'h010, v); check("R2 locked clear ignored", v, 32'h1);

        finish_run();
    end
endmodule